// File: doc/BRIEF.md
# Two-Level Radix Page Table Walker

This block resolves a data-side address translation after a TLB miss. It takes a 64-bit effective address, the access kind (load or store) and the privilege state of the access, and walks a two-level radix tree held in memory. The walk starts from a root pointer register. Each level costs one table-entry read on a simple ready/valid read port. The walk ends in one of two ways: a completed translation (real page number plus the leaf's attribute bits, ready for a TLB fill) or a fault. A fault carries the effective address of the access and a status word that states why the walk failed.

The tree maps a 2 GB window of 4 KB pages. The top level is indexed by effective address bits [30:21] and holds 1024 entries. The second level is indexed by bits [20:12] and holds 512 entries. Table entries are 64 bits wide and sit in memory in big-endian byte order, so each fetched word is byte-reversed before it is decoded. After the leaf is fetched, the walker checks privilege, read/write permission and the referenced/changed bits. It never writes those bits back.

Top module: `ptw_radix2`

## Requirements
- R1: `req_ready` is high exactly when the walker is idle. Every accepted request produces exactly one pulse, one cycle long, on either `done_valid` or `fault_valid`, never on both.
- R2: The first read address is the root base (`root_ptr` bits [55:8], with the low 8 address bits zero) plus 8 × EA[30:21]. A root whose size field `root_ptr[4:0]` is not 10 gives a no-translation fault without any memory read.
- R3: Each fetched word is byte-reversed before it is decoded. In the decoded entry, bit 63 is the valid flag and bit 62 is the leaf flag.
- R4: A top-level entry with valid set, leaf clear and size field [4:0] equal to 9 leads to a second read. Its address is the entry's bits [55:8] (low 8 bits zero) plus 8 × EA[20:12]. Any other top-level entry gives a no-translation fault after exactly one read.
- R5: An effective address with any of bits [63:31] set gives a no-translation fault without any memory read.
- R6: A no-translation fault reports status 0x40000000 for a load and 0x42000000 for a store. A second-level entry that is not both valid and leaf also gives this fault.
- R7: On success, `done_rpn` equals leaf bits [55:12] and `done_attr` equals leaf bits [8:0]. The attribute bits are: execute 0x001, write 0x002, read 0x004, privileged 0x008, non-cacheable 0x020, changed 0x080, referenced 0x100.
- R8: Three cases are permission faults. A leaf with the privileged bit accessed from a non-privileged request. A load to a leaf with read clear. A store to a leaf with write clear. They report status 0x08000000 for a load and 0x0a000000 for a store. Status bit 0x02000000 is set on every fault of a store.
- R9: If permissions pass, two cases fault with status 0x00040000 for a load and 0x02040000 for a store: the referenced bit is clear, or the access is a store and the changed bit is clear. A permission fault takes priority over these.
- R10: `fault_addr` holds the full effective address of the faulting request, including its byte offset within the page.
- R11: At most one table read is outstanding. `mem_rd_valid` stays high, with `mem_rd_addr` unchanged, until `mem_rd_ready` accepts it.
- R12: A request presented while a walk is in progress is not taken and does not alter that walk's result. It is accepted in the first idle cycle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken this cycle |
| req_ea | input | 64 | Effective address to translate |
| req_store | input | 1 | 1 = store, 0 = load |
| req_priv | input | 1 | 1 = access from privileged state |
| root_ptr | input | 64 | Root register: directory base [55:8], top-level size [4:0] |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 56 | Byte address of the 64-bit table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Raw table word, big-endian byte order |
| done_valid | output | 1 | One-cycle pulse: translation complete |
| done_rpn | output | 44 | Real page number |
| done_attr | output | 9 | Leaf attribute bits |
| fault_valid | output | 1 | One-cycle pulse: walk faulted |
| fault_addr | output | 64 | Effective address of the faulting access |
| fault_status | output | 32 | Fault cause word |

## Verification
Two situations can land in the same cycle. In the first, a walk is finishing while the next request already waits on the inputs. The bench holds a second request, a store to an out-of-range address, on the port for the whole of a slow walk. It then checks two things: the first walk's completion comes out unchanged, and the held request is taken only once the walker is idle again, when it faults with its own address and the store no-translation status. In the second, a single leaf carries both a permission violation and a missing referenced or changed bit. The sweep over every 9-bit attribute value, with every load/store and privilege combination, judges these cases against the priority stated in R9.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   // Page geometry and entry layout (architectural, fixed)
   localparam int PG_SHIFT  = 12;
   localparam int SZ_W      = 5;
   localparam int ATTR_W    = 9;
   localparam int ENT_SHIFT = 3;

   // Attribute bit positions inside a leaf entry
   localparam int A_EXEC = 0;
   localparam int A_WR   = 1;
   localparam int A_RD   = 2;
   localparam int A_PRIV = 3;
   localparam int A_NC   = 5;
   localparam int A_CHG  = 7;
   localparam int A_REF  = 8;

   // Fault status codes
   localparam logic [31:0] FS_NOXL   = 32'h4000_0000;
   localparam logic [31:0] FS_STORE  = 32'h0200_0000;
   localparam logic [31:0] FS_PERM   = 32'h0800_0000;
   localparam logic [31:0] FS_REFCHG = 32'h0004_0000;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FETCH_L1,
      S_FETCH_L2,
      S_CHECK,
      S_DONE,
      S_FAULT
   } walk_state_e;

   typedef struct packed {
      logic              valid;
      logic              leaf;
      logic [47:0]       nbase;
      logic [43:0]       rpn;
      logic [ATTR_W-1:0] attr;
      logic [SZ_W-1:0]   size;
   } pt_entry_t;

   function automatic logic [31:0] noxl_status(input logic is_store);
      return FS_NOXL | (is_store ? FS_STORE : 32'h0);
   endfunction

endpackage

// File: rtl/ptw_entry_unpack.sv
module ptw_entry_unpack
   import ptw_pkg::*;
#(
   parameter bit SWAP_BYTES = 1'b1
) (
   input  logic [63:0] raw_i,
   output pt_entry_t   ent_o
);

   logic [63:0] word;

   generate
      if (SWAP_BYTES) begin : g_swap
         for (genvar b = 0; b < 8; b++) begin : g_byte
            assign word[8*b +: 8] = raw_i[8*(7-b) +: 8];
         end
      end else begin : g_native
         assign word = raw_i;
      end
   endgenerate

   assign ent_o.valid = word[63];
   assign ent_o.leaf  = word[62];
   assign ent_o.nbase = word[55:8];
   assign ent_o.rpn   = word[55:12];
   assign ent_o.attr  = word[ATTR_W-1:0];
   assign ent_o.size  = word[SZ_W-1:0];

   logic unused_bits;
   assign unused_bits = ^{word[61:56], word[11:9]};

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
   import ptw_pkg::*;
#(
   parameter int EA_W    = 64,
   parameter int RA_W    = 56,
   parameter int L1_BITS = 10,
   parameter int L2_BITS = 9
) (
   input  logic [EA_W-1:0] ea_i,
   input  logic [RA_W-1:0] root_base_i,
   input  logic [RA_W-1:0] dir_base_i,
   input  logic            lvl2_i,
   output logic [RA_W-1:0] addr_o
);

   localparam int L1_LSB = PG_SHIFT + L2_BITS;
   localparam int TOP    = L1_LSB + L1_BITS;

   logic [RA_W-1:0] off_l1;
   logic [RA_W-1:0] off_l2;

   assign off_l1 = RA_W'(ea_i[L1_LSB +: L1_BITS]) << ENT_SHIFT;
   assign off_l2 = RA_W'(ea_i[PG_SHIFT +: L2_BITS]) << ENT_SHIFT;
   assign addr_o = lvl2_i ? (dir_base_i + off_l2) : (root_base_i + off_l1);

   logic unused_ea;
   assign unused_ea = ^{ea_i[EA_W-1:TOP], ea_i[PG_SHIFT-1:0]};

endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
   import ptw_pkg::*;
(
   input  logic [ATTR_W-1:0] attr_i,
   input  logic              store_i,
   input  logic              priv_i,
   output logic              fault_o,
   output logic [31:0]       status_o
);

   logic perm_bad;
   logic refchg_bad;

   always_comb begin
      perm_bad   = (attr_i[A_PRIV] && !priv_i) ||
                   (store_i ? !attr_i[A_WR] : !attr_i[A_RD]);
      refchg_bad = !attr_i[A_REF] || (store_i && !attr_i[A_CHG]);
      fault_o    = perm_bad || refchg_bad;
      status_o   = (store_i ? FS_STORE : 32'h0) |
                   (perm_bad ? FS_PERM : (refchg_bad ? FS_REFCHG : 32'h0));
   end

   logic unused_attr;
   assign unused_attr = ^{attr_i[A_EXEC], attr_i[4], attr_i[A_NC], attr_i[6]};

endmodule

// File: rtl/ptw_radix2.sv
module ptw_radix2
   import ptw_pkg::*;
#(
   parameter int EA_W         = 64,
   parameter int RA_W         = 56,
   parameter int L1_BITS      = 10,
   parameter int L2_BITS      = 9,
   parameter bit SWAP_ENTRIES = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [EA_W-1:0]        req_ea,
   input  logic                   req_store,
   input  logic                   req_priv,
   input  logic [63:0]            root_ptr,
   output logic                   mem_rd_valid,
   input  logic                   mem_rd_ready,
   output logic [RA_W-1:0]        mem_rd_addr,
   input  logic                   mem_rsp_valid,
   input  logic [63:0]            mem_rsp_data,
   output logic                   done_valid,
   output logic [RA_W-PG_SHIFT-1:0] done_rpn,
   output logic [ATTR_W-1:0]      done_attr,
   output logic                   fault_valid,
   output logic [EA_W-1:0]        fault_addr,
   output logic [31:0]            fault_status
);

   localparam int SPAN_BITS = PG_SHIFT + L2_BITS + L1_BITS;
   localparam int RPN_W     = RA_W - PG_SHIFT;
   localparam logic [SZ_W-1:0] L1_SZ = SZ_W'(L1_BITS);
   localparam logic [SZ_W-1:0] L2_SZ = SZ_W'(L2_BITS);

   // Elaboration-time parameter checks
   generate
      if (RA_W > 56 || RA_W < 20) begin : g_bad_ra
         $error("RA_W must lie in 20..56");
      end
      if (L1_BITS < 1 || L1_BITS > 31 || L2_BITS < 1 || L2_BITS > 31) begin : g_bad_lvl
         $error("level index widths must lie in 1..31");
      end
      if (EA_W <= SPAN_BITS) begin : g_bad_ea
         $error("EA_W must exceed the mapped span");
      end
   endgenerate

   walk_state_e         state_q;
   logic [EA_W-1:0]     ea_q;
   logic                store_q;
   logic                priv_q;
   logic                issued_q;
   logic [RA_W-1:0]     root_base_q;
   logic [RA_W-1:0]     dir_base_q;
   logic [RPN_W-1:0]    rpn_q;
   logic [ATTR_W-1:0]   attr_q;
   logic [31:0]         sts_q;

   pt_entry_t           ent;
   logic                chk_fault;
   logic [31:0]         chk_status;
   logic                range_bad;
   logic                root_bad;
   logic                dir_ok;
   logic                leaf_ok;

   ptw_entry_unpack #(
      .SWAP_BYTES (SWAP_ENTRIES)
   ) u_unpack (
      .raw_i (mem_rsp_data),
      .ent_o (ent)
   );

   ptw_addr_gen #(
      .EA_W    (EA_W),
      .RA_W    (RA_W),
      .L1_BITS (L1_BITS),
      .L2_BITS (L2_BITS)
   ) u_addr (
      .ea_i        (ea_q),
      .root_base_i (root_base_q),
      .dir_base_i  (dir_base_q),
      .lvl2_i      (state_q == S_FETCH_L2),
      .addr_o      (mem_rd_addr)
   );

   ptw_perm_check u_perm (
      .attr_i   (attr_q),
      .store_i  (store_q),
      .priv_i   (priv_q),
      .fault_o  (chk_fault),
      .status_o (chk_status)
   );

   assign range_bad = (req_ea[EA_W-1:SPAN_BITS] != '0);
   assign root_bad  = (root_ptr[SZ_W-1:0] != L1_SZ);
   assign dir_ok    = ent.valid && !ent.leaf && (ent.size == L2_SZ);
   assign leaf_ok   = ent.valid && ent.leaf;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         ea_q        <= '0;
         store_q     <= 1'b0;
         priv_q      <= 1'b0;
         issued_q    <= 1'b0;
         root_base_q <= '0;
         dir_base_q  <= '0;
         rpn_q       <= '0;
         attr_q      <= '0;
         sts_q       <= '0;
      end else begin
         unique case (state_q)
            S_IDLE: begin
               if (req_valid) begin
                  ea_q        <= req_ea;
                  store_q     <= req_store;
                  priv_q      <= req_priv;
                  issued_q    <= 1'b0;
                  root_base_q <= {root_ptr[RA_W-1:8], 8'h00};
                  if (range_bad || root_bad) begin
                     sts_q   <= noxl_status(req_store);
                     state_q <= S_FAULT;
                  end else begin
                     state_q <= S_FETCH_L1;
                  end
               end
            end
            S_FETCH_L1, S_FETCH_L2: begin
               if (!issued_q) begin
                  if (mem_rd_ready) begin
                     issued_q <= 1'b1;
                  end
               end else if (mem_rsp_valid) begin
                  issued_q <= 1'b0;
                  if (state_q == S_FETCH_L1) begin
                     if (dir_ok) begin
                        dir_base_q <= {ent.nbase[RA_W-9:0], 8'h00};
                        state_q    <= S_FETCH_L2;
                     end else begin
                        sts_q   <= noxl_status(store_q);
                        state_q <= S_FAULT;
                     end
                  end else begin
                     if (leaf_ok) begin
                        rpn_q   <= ent.rpn[RPN_W-1:0];
                        attr_q  <= ent.attr;
                        state_q <= S_CHECK;
                     end else begin
                        sts_q   <= noxl_status(store_q);
                        state_q <= S_FAULT;
                     end
                  end
               end
            end
            S_CHECK: begin
               if (chk_fault) begin
                  sts_q   <= chk_status;
                  state_q <= S_FAULT;
               end else begin
                  state_q <= S_DONE;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   logic unused_root;
   assign unused_root = ^{root_ptr[63:RA_W], root_ptr[7:SZ_W]};

   assign req_ready    = (state_q == S_IDLE);
   assign mem_rd_valid = ((state_q == S_FETCH_L1) || (state_q == S_FETCH_L2)) && !issued_q;
   assign done_valid   = (state_q == S_DONE);
   assign fault_valid  = (state_q == S_FAULT);
   assign done_rpn     = rpn_q;
   assign done_attr    = attr_q;
   assign fault_addr   = ea_q;
   assign fault_status = sts_q;

endmodule

// File: rtl/ptw_radix2_chk.sv
module ptw_radix2_chk #(
   parameter int EA_W = 64,
   parameter int RA_W = 56
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [EA_W-1:0] req_ea,
   input logic            req_store,
   input logic            mem_rd_valid,
   input logic            mem_rd_ready,
   input logic [RA_W-1:0] mem_rd_addr,
   input logic            mem_rsp_valid,
   input logic            done_valid,
   input logic            fault_valid,
   input logic [EA_W-1:0] fault_addr,
   input logic [31:0]     fault_status
);

   logic            busy;
   logic            cap_store;
   logic [EA_W-1:0] cap_ea;
   logic [1:0]      out_cnt;
   logic            rd_acc;
   logic            rsp_dec;
   logic [31:0]     sts_core;

   assign rd_acc   = mem_rd_valid && mem_rd_ready;
   assign rsp_dec  = mem_rsp_valid && (out_cnt != 2'd0);
   assign sts_core = fault_status & ~32'h0200_0000;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         cap_store <= 1'b0;
         cap_ea    <= '0;
         out_cnt   <= 2'd0;
      end else begin
         if (req_valid && req_ready) begin
            busy      <= 1'b1;
            cap_store <= req_store;
            cap_ea    <= req_ea;
         end else if (done_valid || fault_valid) begin
            busy <= 1'b0;
         end
         out_cnt <= out_cnt + 2'(rd_acc) - 2'(rsp_dec);
      end
   end

   p_ready_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !(done_valid || fault_valid || mem_rd_valid));

   p_pulse_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_valid, fault_valid}));

   p_done_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid && req_ready);

   p_fault_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |=> !fault_valid && req_ready);

   p_pulse_owned_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid || fault_valid) |-> busy);

   p_status_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (sts_core == 32'h4000_0000 || sts_core == 32'h0800_0000 ||
                       sts_core == 32'h0004_0000));

   p_store_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (fault_status[25] == cap_store));

   p_fault_ea_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_valid |-> (fault_addr == cap_ea));

   p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr));

   p_one_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_valid |-> (out_cnt == 2'd0));

   p_busy_closed_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);

endmodule

bind ptw_radix2 ptw_radix2_chk #(
   .EA_W (EA_W),
   .RA_W (RA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .req_ea       (req_ea),
   .req_store    (req_store),
   .mem_rd_valid (mem_rd_valid),
   .mem_rd_ready (mem_rd_ready),
   .mem_rd_addr  (mem_rd_addr),
   .mem_rsp_valid(mem_rsp_valid),
   .done_valid   (done_valid),
   .fault_valid  (fault_valid),
   .fault_addr   (fault_addr),
   .fault_status (fault_status)
);

// File: tb/ptw_radix2_bench.sv
module ptw_radix2_bench;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_ea = '0;
   logic        req_store = 1'b0;
   logic        req_priv = 1'b0;
   logic [63:0] root_ptr = '0;
   logic        mem_rd_valid;
   logic        mem_rd_ready = 1'b0;
   logic [55:0] mem_rd_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        done_valid;
   logic [43:0] done_rpn;
   logic [8:0]  done_attr;
   logic        fault_valid;
   logic [63:0] fault_addr;
   logic [31:0] fault_status;

   int n_checks = 0;
   int n_fail   = 0;

   // memory model state
   logic [55:0] m_l1a, m_l2a, pend_addr;
   logic [63:0] m_pde, m_pte;
   logic [55:0] rd_hist [4];
   int rd_total = 0;
   int cfg_stall = 0, cfg_lat = 1, stall_left = 0, lat_left = 0;
   bit pending = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptw_radix2 u_ptw_radix2 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
      .req_store(req_store), .req_priv(req_priv), .root_ptr(root_ptr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done_valid(done_valid), .done_rpn(done_rpn), .done_attr(done_attr),
      .fault_valid(fault_valid), .fault_addr(fault_addr), .fault_status(fault_status)
   );

   function automatic logic [63:0] swap64(input logic [63:0] v);
      logic [63:0] r;
      for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
      return r;
   endfunction

   function automatic logic [63:0] lookup(input logic [55:0] a);
      if (a == m_l1a) return swap64(m_pde);
      if (a == m_l2a) return swap64(m_pte);
      return 64'h0;
   endfunction

   // Memory: stall before accepting, fixed latency before answering
   always @(negedge clk) begin
      mem_rsp_valid = 1'b0;
      if (!rst_n) begin
         mem_rd_ready = 1'b0;
         pending      = 1'b0;
      end else begin
         if (mem_rd_ready) begin
            mem_rd_ready = 1'b0;
            pending      = 1'b1;
            lat_left     = cfg_lat;
         end else if (mem_rd_valid && !pending) begin
            if (stall_left == 0) begin
               mem_rd_ready = 1'b1;
               pend_addr    = mem_rd_addr;
               rd_hist[rd_total % 4] = mem_rd_addr;
               rd_total++;
            end else begin
               stall_left--;
            end
         end else if (!mem_rd_valid && !pending) begin
            stall_left = cfg_stall;
         end
         if (pending) begin
            if (lat_left <= 1) begin
               mem_rsp_valid = 1'b1;
               mem_rsp_data  = lookup(pend_addr);
               pending       = 1'b0;
               stall_left    = cfg_stall;
            end else begin
               lat_left--;
            end
         end
      end
   end

   task automatic chk(input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   // Expected leaf status from R8 (permission) then R9 (reference/change)
   function automatic logic [31:0] exp_leaf_status(input logic [8:0] at,
                                                   input logic st, input logic pv);
      logic [31:0] sb;
      sb = st ? 32'h0200_0000 : 32'h0;
      if ((at[3] && !pv) || (st ? !at[1] : !at[2])) return sb | 32'h0800_0000;
      if (!at[8] || (st && !at[7])) return sb | 32'h0004_0000;
      return 32'h0;
   endfunction

   task automatic walk(input logic [63:0] ea, input logic st, input logic pv,
                       input logic [63:0] root, input logic [63:0] pde,
                       input logic [63:0] pte, input int stall, input int lat);
      int exp_reads, base, c;
      bit exp_fault, got;
      logic [31:0] exp_sts;
      string tag;
      bit seen_done, seen_fault;
      logic [63:0] f_addr;
      logic [31:0] f_sts;
      logic [43:0] d_rpn;
      logic [8:0]  d_attr;

      m_l1a = {root[55:8], 8'h00} + {43'b0, ea[30:21], 3'b000};
      m_l2a = {pde[55:8], 8'h00} + {44'b0, ea[20:12], 3'b000};
      m_pde = pde;
      m_pte = pte;

      exp_fault = 1'b1;
      exp_sts   = st ? 32'h4200_0000 : 32'h4000_0000;
      tag       = "R6";
      if (ea[63:31] != '0) begin
         exp_reads = 0; tag = "R5";
      end else if (root[4:0] != 5'd10) begin
         exp_reads = 0; tag = "R2";
      end else if (!(pde[63] && !pde[62] && pde[4:0] == 5'd9)) begin
         exp_reads = 1; tag = "R4";
      end else if (!(pte[63] && pte[62])) begin
         exp_reads = 2;
      end else begin
         exp_reads = 2;
         exp_sts   = exp_leaf_status(pte[8:0], st, pv);
         exp_fault = (exp_sts != 0);
         tag       = exp_sts[27] ? "R8" : "R9";
      end

      @(negedge clk);
      cfg_stall = stall;
      cfg_lat   = lat;
      base      = rd_total;
      chk("R1", "ready when idle", {63'b0, req_ready}, 64'd1);
      req_valid = 1'b1; req_ea = ea; req_store = st; req_priv = pv; root_ptr = root;
      @(negedge clk);
      req_valid = 1'b0;
      got = 1'b0;
      for (c = 0; c < 60 && !got; c++) begin
         if (done_valid || fault_valid) got = 1'b1;
         else @(negedge clk);
      end
      seen_done = done_valid; seen_fault = fault_valid;
      f_addr = fault_addr; f_sts = fault_status; d_rpn = done_rpn; d_attr = done_attr;
      chk("R1", "outcome pulse seen", {63'b0, got}, 64'd1);
      chk(tag, "fault flag", {63'b0, seen_fault}, {63'b0, exp_fault});
      chk("R1", "done flag", {63'b0, seen_done}, {63'b0, !exp_fault});
      if (exp_fault) begin
         chk(tag, "fault status", {32'b0, f_sts}, {32'b0, exp_sts});
         chk("R10", "fault address", f_addr, ea);
      end else begin
         chk("R3 R7", "real page number", {20'b0, d_rpn}, {20'b0, pte[55:12]});
         chk("R7", "attributes", {55'b0, d_attr}, {55'b0, pte[8:0]});
      end
      chk("R11 R5", "read count", 64'(rd_total - base), 64'(exp_reads));
      if (exp_reads >= 1) chk("R2", "top-level read address", {8'b0, rd_hist[base % 4]}, {8'b0, m_l1a});
      if (exp_reads >= 2) chk("R4", "second-level read address", {8'b0, rd_hist[(base + 1) % 4]}, {8'b0, m_l2a});
      @(negedge clk);
      chk("R1", "single-cycle pulse", {62'b0, done_valid, fault_valid}, 64'd0);
   endtask

   localparam logic [63:0] ROOT_OK = 64'h0000_0000_0002_0000 | 64'd10;
   localparam logic [63:0] PDE_OK  = 64'h8000_0000_0003_0000 | 64'd9;
   localparam logic [63:0] PTE_HI  = 64'hC000_0000_0000_0000;
   localparam logic [63:0] FULL    = 64'h0000_0000_0000_0186; // R,W,C,REF

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R1)
      chk("R1", "reset ready", {63'b0, req_ready}, 64'd1);
      chk("R1", "reset pulses", {62'b0, done_valid, fault_valid}, 64'd0);
      chk("R11", "reset read request", {63'b0, mem_rd_valid}, 64'd0);

      // R6: empty directory slot, load and store
      walk(64'h0000_0000_0012_3008, 1'b0, 1'b0, ROOT_OK, 64'h0, 64'h0, 0, 1);
      walk(64'h0000_0000_0012_3008, 1'b1, 1'b0, ROOT_OK, 64'h0, 64'h0, 1, 2);
      // R3 R7: success, asymmetric page number, byte offset in EA
      walk(64'h0000_0000_5a3c_7f18, 1'b0, 1'b0, ROOT_OK, PDE_OK,
           PTE_HI | 64'h00ab_cdef_1234_5000 | FULL | 64'h021, 2, 3);
      // R6: empty leaf slot; valid but non-leaf second-level entry
      walk(64'h0000_0000_0014_9168, 1'b0, 1'b0, ROOT_OK, PDE_OK, 64'h0, 0, 1);
      walk(64'h0000_0000_0014_9168, 1'b1, 1'b1, ROOT_OK, PDE_OK,
           64'h8000_0000_0000_5000 | FULL, 0, 1);
      // R4: leaf at the top level, and wrong next-level size
      walk(64'h0000_0000_0010_a000, 1'b0, 1'b0, ROOT_OK, PDE_OK | 64'h4000_0000_0000_0000, 64'h0, 0, 1);
      walk(64'h0000_0000_0010_a000, 1'b1, 1'b0, ROOT_OK, (PDE_OK & ~64'h1f) | 64'd8, 64'h0, 1, 1);
      // R5: address beyond the mapped window; R2: wrong root size
      walk(64'h0000_0000_8000_0000, 1'b0, 1'b0, ROOT_OK, PDE_OK, PTE_HI | FULL, 0, 1);
      walk(64'h0000_0000_0039_fffd, 1'b1, 1'b0, (ROOT_OK & ~64'h1f) | 64'd9, PDE_OK, PTE_HI | FULL, 0, 1);

      // R8 R9 R7: every attribute value, every access kind and privilege
      for (int a = 0; a < 512; a++) begin
         for (int m = 0; m < 4; m++) begin
            logic [63:0] ea, pa;
            ea = (64'((a * 37) % 1024) << 21) | (64'(a % 512) << 12) | 64'((a * 8 + m) % 4096);
            pa = 64'h00ab_cd00_0000_0000 + (64'(a) << 12);
            walk(ea, m[0], m[1], ROOT_OK, PDE_OK, PTE_HI | pa | 64'(a), a % 3, 1 + (m % 2));
         end
      end

      // R12: second request held on the port during a slow walk
      begin
         bit got;
         int base;
         logic [43:0] rpn_seen;
         m_l1a = {ROOT_OK[55:8], 8'h00} + {43'b0, 10'h155, 3'b000};
         m_l2a = {PDE_OK[55:8], 8'h00} + {44'b0, 9'h0aa, 3'b000};
         m_pde = PDE_OK;
         m_pte = PTE_HI | 64'h0012_3456_7000 | FULL;
         @(negedge clk);
         cfg_stall = 3; cfg_lat = 3; base = rd_total;
         req_valid = 1'b1; req_store = 1'b0; req_priv = 1'b0; root_ptr = ROOT_OK;
         req_ea = {33'b0, 10'h155, 9'h0aa, 12'h040};
         @(negedge clk);
         req_ea = 64'h0000_0100_0000_0abc; req_store = 1'b1;
         got = 1'b0;
         for (int c = 0; c < 60 && !got; c++) begin
            if (done_valid || fault_valid) got = 1'b1;
            else @(negedge clk);
         end
         rpn_seen = done_rpn;
         chk("R12", "first walk completes", {62'b0, done_valid, fault_valid}, 64'd2);
         chk("R12", "first walk page number", {20'b0, rpn_seen}, 64'h0000_0012_3456_7);
         chk("R12", "first walk reads", 64'(rd_total - base), 64'd2);
         @(negedge clk);
         chk("R12", "held request idle cycle", {62'b0, done_valid, fault_valid}, 64'd0);
         chk("R12", "taken when idle", {63'b0, req_ready}, 64'd1);
         @(negedge clk);
         req_valid = 1'b0;
         chk("R12", "held request faults", {63'b0, fault_valid}, 64'd1);
         chk("R10", "held request address", fault_addr, 64'h0000_0100_0000_0abc);
         chk("R6", "held store status", {32'b0, fault_status}, 64'h4200_0000);
         @(negedge clk);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule